// File: doc/BRIEF.md
# PHY Reset and Receive-PLL Lock Sequencer

This block brings a serial PHY out of reset and confirms that its receive PLL has settled. It does not talk to the PHY directly. Instead it issues a short series of commands to a separate control-port handshake master, which owns the low-level capture and acknowledge protocol. A one-cycle `start` request launches the sequence. The block first selects the PHY clock/reset register and writes a value with the reset bit set. That write uses the master's no-acknowledge form, because a PHY that is resetting cannot answer.

After the reset, the block runs a bounded poll. Before each attempt it waits a fixed number of cycles. It then selects the lane status register, reads it and tests the PLL-stable bit. It stops as soon as the bit is seen. If the bit is never seen, it stops after a fixed number of attempts. A handshake error reported by the master on any address or read step ends the sequence at once.

The outcome is given as a one-cycle `done` pulse together with a two-bit result code, which stays valid until the next completion. Commands travel over a valid/ready channel: the block holds `cmd_valid`, `cmd_op` and `cmd_data` steady until the master raises `cmd_ready`, so the master may stall it for any number of cycles. Responses come back as one-cycle `rsp_valid` strobes and cannot be back-pressured. The block only acts on a response while it is waiting for one.

Top module: `phy_lock_seq`

## Requirements
- R1: During and immediately after reset, `busy`, `done` and `cmd_valid` are 0 and `result` is 0.
- R2: A `start` seen while idle raises `busy`, and the first command issued is op 0 (address select) carrying `RST_REG` (default 16'h7F3F).
- R3: Once that address is acknowledged without error, the second command is op 2 (write, no acknowledge expected) carrying `RST_VAL`, whose bit 0 is set. The block goes on as soon as the master accepts it and waits for no response.
- R4: Every poll attempt is preceded by a wait of `DELAY_CYC` cycles. With `cmd_ready` held high, the next address command is accepted exactly `DELAY_CYC`+1 cycles after the preceding reset write is accepted.
- R5: Each poll attempt issues op 0 carrying `STAT_REG` (default 16'h2003), then op 3 (read). If bit `LOCK_BIT` (default 1) of the read data is 1, the sequence ends with result 2'b00 (locked). No other data bit matters.
- R6: A read whose lock bit is 0 starts another wait-and-poll. After `MAX_TRIES` (default 10) failed reads the sequence ends with result 2'b01 (lock timeout), having issued exactly `MAX_TRIES` reads.
- R7: A response with `rsp_err` = 1 to any address or read command ends the sequence immediately with result 2'b10 (handshake error), and no further command is issued.
- R8: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_op` and `cmd_data` hold their values into the next cycle.
- R9: Completion gives `done` = 1 for exactly one cycle, in the same cycle that `busy` falls. `result` holds its value until the next completion.
- R10: `start` has no effect while `busy` is 1. A `start` presented in the cycle that `done` is 1 launches a new sequence.
- R11: A response strobe that arrives when the block is not waiting for a response (idle, or during the wait interval) is ignored, including its error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to run the reset-and-lock sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 2 | 00 locked, 01 lock timeout, 10 handshake error |
| cmd_valid | output | 1 | Command offered to the handshake master |
| cmd_ready | input | 1 | Master accepts the command this cycle |
| cmd_op | output | 2 | 0 address, 1 write with ack, 2 write without ack, 3 read |
| cmd_data | output | DATA_W | Register address or write value |
| rsp_valid | input | 1 | One-cycle response strobe from the master |
| rsp_err | input | 1 | Handshake error flag of the response |
| rsp_data | input | DATA_W | Read data of the response |

## Verification
There is one cycle in which a finishing sequence and a new request meet. The completion strobe `done` and a fresh `start` can fall in that same cycle, because `busy` has already dropped there. The bench holds back until it sees `done` high at a falling edge and then drives `start` for that single cycle. It judges the outcome at the ports: `busy` must be high one cycle later, the second run must issue a full new command series and produce a second `done`, and the command count must match two complete runs. As a counterpart, a `start` held high in the middle of a run must leave both the command count and the number of `done` strobes unchanged.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [1:0] {
    OP_ADDR    = 2'd0,
    OP_WR_ACK  = 2'd1,
    OP_WR_NACK = 2'd2,
    OP_READ    = 2'd3
  } ctl_op_e;

  typedef enum logic [1:0] {
    RES_LOCKED  = 2'd0,
    RES_TIMEOUT = 2'd1,
    RES_HS_ERR  = 2'd2
  } seq_res_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_ADDR,
    ST_RST_ADDR_W,
    ST_RST_WR,
    ST_WAIT,
    ST_POLL_ADDR,
    ST_POLL_ADDR_W,
    ST_POLL_RD,
    ST_POLL_RD_W
  } seq_state_e;

endpackage

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
  parameter int unsigned CYCLES = 64,
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= CW'(CYCLES - 1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/seq_try_counter.sv
module seq_try_counter #(
  parameter int unsigned LIMIT = 10,
  localparam int unsigned TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  logic [TW-1:0] tries_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tries_q <= '0;
    else if (clr)   tries_q <= '0;
    else if (inc)   tries_q <= tries_q + 1'b1;
  end

  assign last = (tries_q == TW'(LIMIT - 1));
endmodule

// File: rtl/phy_lock_seq.sv
module phy_lock_seq
  import phy_seq_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned DELAY_CYC = 64,
  parameter int unsigned MAX_TRIES = 10,
  parameter int unsigned LOCK_BIT  = 1,
  parameter logic [DATA_W-1:0] RST_REG  = 16'h7F3F,
  parameter logic [DATA_W-1:0] RST_VAL  = 16'h0001,
  parameter logic [DATA_W-1:0] STAT_REG = 16'h2003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [1:0]        result,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [DATA_W-1:0] rsp_data
);
  seq_state_e state_q, state_d;
  logic       fin;
  seq_res_e   fin_code;
  logic       wait_load, wait_done;
  logic       try_clr, try_inc, try_last;
  logic       locked;
  logic [1:0] result_q;
  logic       done_q;

  assign locked = rsp_data[LOCK_BIT];

  seq_wait_timer #(.CYCLES(DELAY_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(wait_load), .expired(wait_done)
  );

  seq_try_counter #(.LIMIT(MAX_TRIES)) u_tries (
    .clk(clk), .rst_n(rst_n), .clr(try_clr), .inc(try_inc), .last(try_last)
  );

  always_comb begin
    state_d   = state_q;
    fin       = 1'b0;
    fin_code  = RES_LOCKED;
    wait_load = 1'b0;
    try_clr   = 1'b0;
    try_inc   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_RST_ADDR;
        try_clr = 1'b1;
      end
      ST_RST_ADDR:   if (cmd_ready) state_d = ST_RST_ADDR_W;
      ST_RST_ADDR_W: if (rsp_valid) begin
        if (rsp_err) begin
          fin = 1'b1; fin_code = RES_HS_ERR; state_d = ST_IDLE;
        end else state_d = ST_RST_WR;
      end
      ST_RST_WR: if (cmd_ready) begin
        state_d   = ST_WAIT;
        wait_load = 1'b1;
      end
      ST_WAIT:        if (wait_done) state_d = ST_POLL_ADDR;
      ST_POLL_ADDR:   if (cmd_ready) state_d = ST_POLL_ADDR_W;
      ST_POLL_ADDR_W: if (rsp_valid) begin
        if (rsp_err) begin
          fin = 1'b1; fin_code = RES_HS_ERR; state_d = ST_IDLE;
        end else state_d = ST_POLL_RD;
      end
      ST_POLL_RD:     if (cmd_ready) state_d = ST_POLL_RD_W;
      ST_POLL_RD_W: if (rsp_valid) begin
        if (rsp_err) begin
          fin = 1'b1; fin_code = RES_HS_ERR; state_d = ST_IDLE;
        end else if (locked) begin
          fin = 1'b1; fin_code = RES_LOCKED; state_d = ST_IDLE;
        end else if (try_last) begin
          fin = 1'b1; fin_code = RES_TIMEOUT; state_d = ST_IDLE;
        end else begin
          try_inc   = 1'b1;
          wait_load = 1'b1;
          state_d   = ST_WAIT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      done_q   <= 1'b0;
      result_q <= 2'b00;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (fin) result_q <= fin_code;
    end
  end

  always_comb begin
    cmd_valid = 1'b1;
    cmd_op    = OP_ADDR;
    cmd_data  = '0;
    unique case (state_q)
      ST_RST_ADDR:  cmd_data = RST_REG;
      ST_RST_WR:  begin cmd_op = OP_WR_NACK; cmd_data = RST_VAL; end
      ST_POLL_ADDR: cmd_data = STAT_REG;
      ST_POLL_RD:   cmd_op = OP_READ;
      default:      cmd_valid = 1'b0;
    endcase
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign result = result_q;
endmodule

// File: rtl/phy_lock_seq_chk.sv
module phy_lock_seq_chk #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned MAX_TRIES = 10,
  localparam int unsigned RW = $clog2(MAX_TRIES + 2) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [1:0]        result,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [DATA_W-1:0] cmd_data
);
  logic [RW-1:0] rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                         rd_cnt <= '0;
    else if (start && !busy)                            rd_cnt <= '0;
    else if (cmd_valid && cmd_ready && cmd_op == 2'd3)  rd_cnt <= rd_cnt + 1'b1;
  end

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_data));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9
  done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result != 2'b11);

  // R2
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  // R7
  cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);

  // R6
  read_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= RW'(MAX_TRIES));

  // R6
  timeout_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && result == 2'b01 |-> rd_cnt == RW'(MAX_TRIES));
endmodule

bind phy_lock_seq phy_lock_seq_chk #(.DATA_W(DATA_W), .MAX_TRIES(MAX_TRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .result(result), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_data(cmd_data)
);

// File: tb/phy_lock_seq_bench.sv
module phy_lock_seq_bench;
  localparam int DLY  = 8;
  localparam int TRY  = 10;
  localparam int NV   = 7;

  // fields: lock_at[26:19] err_at[18:11] res[10:9] ncmd[8:1] stall[0]
  localparam logic [26:0] VEC [NV] = '{
    {8'd0,  8'd255, 2'd0, 8'd4,  1'b0},
    {8'd3,  8'd255, 2'd0, 8'd10, 1'b1},
    {8'd99, 8'd255, 2'd1, 8'd22, 1'b0},
    {8'd9,  8'd255, 2'd0, 8'd22, 1'b0},
    {8'd99, 8'd0,   2'd2, 8'd1,  1'b0},
    {8'd99, 8'd5,   2'd2, 8'd6,  1'b1},
    {8'd0,  8'd3,   2'd2, 8'd4,  1'b0}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, cmd_valid;
  logic [1:0] result, cmd_op;
  logic [15:0] cmd_data;
  logic cmd_ready = 1, rsp_valid = 0, rsp_err = 0;
  logic [15:0] rsp_data = '0;

  int checks = 0, errors = 0;
  int cyc = 0, ncmd = 0, nrd = 0, ndone = 0;
  int lock_at = 255, err_at = 255;
  bit stall = 0, spur = 0, spur_err = 0;
  bit pend = 0, p_err = 0;
  int lat = 0;
  logic [15:0] p_data;
  logic [1:0] log_op [32];
  logic [15:0] log_dat [32];
  int log_cyc [32];

  always #10 clk = ~clk;

  phy_lock_seq #(.DATA_W(16), .DELAY_CYC(DLY), .MAX_TRIES(TRY)) u_phy_lock_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .result(result), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_data(rsp_data)
  );

  // handshake master model, acting at falling edges
  always @(negedge clk) begin
    cyc++;
    if (done) ndone++;
    rsp_valid = 0;
    rsp_err   = 0;
    if (pend) begin
      if (lat == 0) begin
        rsp_valid = 1; rsp_err = p_err; rsp_data = p_data; pend = 0;
      end else lat--;
    end
    if (spur) begin
      rsp_valid = 1; rsp_err = spur_err; rsp_data = 16'h0002; spur = 0;
    end
    cmd_ready = stall ? cyc[0] : 1'b1;
    if (rst_n && cmd_valid && cmd_ready) begin
      if (ncmd < 32) begin
        log_op[ncmd] = cmd_op; log_dat[ncmd] = cmd_data; log_cyc[ncmd] = cyc;
      end
      if (cmd_op != 2'd2) begin
        pend  = 1;
        lat   = 1;
        p_err = (ncmd == err_at);
        p_data = 16'h0000;
        if (cmd_op == 2'd3) begin
          p_data = (nrd >= lock_at) ? 16'h0002 : 16'hFFFD;
          nrd++;
        end
      end
      ncmd++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    ncmd = 0; nrd = 0; ndone = 0;
  endtask

  task automatic pulse_start();
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) break;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && cmd_valid == 0, "R1", "outputs in reset", {busy, done, cmd_valid}, 0);
    chk(result == 2'b00, "R1", "result in reset", result, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && cmd_valid == 0, "R1", "idle after reset", {busy, cmd_valid}, 0);

    for (int v = 0; v < NV; v++) begin
      lock_at = int'(VEC[v][26:19]);
      err_at  = int'(VEC[v][18:11]);
      stall   = VEC[v][0];
      @(negedge clk);
      clear_log();
      pulse_start();
      wait_done();
      repeat (4) @(negedge clk);
      chk(result == VEC[v][10:9], "R5/R6/R7", $sformatf("vec %0d result", v), result, VEC[v][10:9]);
      chk(ncmd == int'(VEC[v][8:1]), "R6/R7", $sformatf("vec %0d command count", v), ncmd, VEC[v][8:1]);
      chk(ndone == 1 && busy == 0, "R9", $sformatf("vec %0d single done", v), ndone, 1);
      chk(log_op[0] == 2'd0 && log_dat[0] == 16'h7F3F, "R2", "reset address", log_dat[0], 16'h7F3F);
      if (ncmd >= 2)
        chk(log_op[1] == 2'd2 && log_dat[1][0], "R3", "reset write", log_op[1], 2);
      if (ncmd >= 4)
        chk(log_op[2] == 2'd0 && log_dat[2] == 16'h2003 && log_op[3] == 2'd3,
            "R5", "poll address then read", log_dat[2], 16'h2003);
      if (ncmd >= 3 && !stall)
        chk(log_cyc[2] - log_cyc[1] == DLY + 1, "R4", "wait before poll",
            log_cyc[2] - log_cyc[1], DLY + 1);
      if (stall)
        chk(result == VEC[v][10:9], "R8", "outcome under back-pressure", result, VEC[v][10:9]);
    end
    stall = 0; lock_at = 0; err_at = 255;

    // R10: start while busy ignored
    @(negedge clk);
    clear_log();
    pulse_start();
    repeat (2) @(negedge clk);
    start = 1;
    repeat (3) @(negedge clk);
    start = 0;
    wait_done();
    repeat (4) @(negedge clk);
    chk(ncmd == 4 && ndone == 1, "R10", "start while busy ignored", ncmd, 4);

    // R10: start in the done cycle restarts
    clear_log();
    pulse_start();
    wait_done();
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R10", "restart in done cycle", busy, 1);
    wait_done();
    repeat (4) @(negedge clk);
    chk(ncmd == 8 && ndone == 2 && result == 2'b00, "R10", "second run complete", ncmd, 8);

    // R11: stray response while idle
    clear_log();
    spur = 1; spur_err = 1;
    repeat (3) @(negedge clk);
    chk(busy == 0 && cmd_valid == 0 && ndone == 0, "R11", "stray response when idle", ndone, 0);

    // R11: stray error response during the wait interval
    clear_log();
    pulse_start();
    for (int i = 0; i < 100; i++) begin
      if (ncmd >= 2) break;
      @(negedge clk);
    end
    @(negedge clk);
    spur = 1; spur_err = 1;
    wait_done();
    repeat (3) @(negedge clk);
    chk(result == 2'b00 && ncmd == 4, "R11", "stray error during wait", result, 0);

    // R9: result held after completion
    repeat (10) @(negedge clk);
    chk(result == 2'b00 && done == 0, "R9", "result holds", result, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule